// File: doc/BRIEF.md
# Playback Byte FIFO Host Write Port

This block is the host-facing half of a playback path. A host pushes audio one byte at a time into a byte-wide FIFO, and a digital-to-analog converter takes one whole stereo sample from it on every sample-period tick. A stereo sample is four bytes: left low, left high, right low, right high. The block reports which byte it expects next. It also raises a request flag while at least one more sample fits, and a half-empty flag while half the storage is free.

When a tick finds no whole sample in the FIFO, the converter output is starved. A mode pin then chooses between a midscale output of zero and holding the last sample. The first starved tick is a grace period. A second starved tick in a row sets a sticky underrun flag. That flag drops only when the host completes a four-byte sample.

Host writes use a valid/ready handshake. A byte transfers on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low only while the FIFO holds its full depth, and a byte offered then is not taken. `wr_valid` may be held high with the same byte until `wr_ready` returns. The tick, the mode and all status pins are plain levels.

Top module: `pio_playback_port`

## Requirements
- R1: While reset is asserted, `pio_status` is 0x00, `underrun` is 0 and `dac_sample` is 0.
- R2: `pio_status` bit 5 is 1 when the next byte belongs to the left channel and 0 for the right channel. Bit 4 is 1 when the next byte is the upper byte and 0 for the lower byte. Bits 3..0 are 0. The byte order within a sample is left low, left high, right low, right high, so the (bit5, bit4) pair steps 10, 11, 00, 01.
- R3: A byte is accepted only when `wr_valid` and `wr_ready` are both high. `wr_ready` is 0 exactly when the FIFO holds DEPTH (64) bytes. A refused byte changes neither the FIFO contents nor the byte position.
- R4: `pio_status` bit 6 is 1 when at least 4 bytes are free.
- R5: `pio_status` bit 7 is 1 when at least DEPTH/2 (32) bytes are free.
- R6: A `tick` with at least 4 bytes stored removes one sample. On the next clock, `dac_sample` = {left high, left low, right high, right low}, which is bytes {1,0,3,2} of the sample in write order.
- R7: A `tick` with fewer than 4 bytes stored is starved. `dac_sample` becomes 0 if `repeat_mode` is 0 and keeps its previous value if `repeat_mode` is 1. `dac_sample` changes only after a tick.
- R8: The first starved tick after a successful tick does not set `underrun`. A second consecutive starved tick sets it, and further ticks leave it set.
- R9: `underrun` clears on the clock edge that accepts the fourth byte of a sample. This also cancels the pending grace state, and it wins over a setting tick in the same cycle.
- R10: Status bits reflect the FIFO state after the same clock edge that changed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host offers a byte |
| wr_data | input | 8 | Host byte |
| wr_ready | output | 1 | FIFO can take a byte |
| tick | input | 1 | One-cycle sample-period pulse |
| repeat_mode | input | 1 | 1: hold last sample when starved, 0: midscale |
| dac_sample | output | 32 | {left[15:0], right[15:0]} to the converter |
| pio_status | output | 8 | {half_free, req, left, upper, 4'b0} |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench targets the grace window. A design that sets the flag on the first starved tick fails the single-starve vector, and one that never sets it fails the second. It fills the FIFO and then offers an extra byte. A design that takes that byte or advances the byte position shows a shifted position or a corrupted later sample. It pops across the 28/32-free boundary, where an off-by-one half-empty compare flips at the wrong pop. It also checks the byte packing against a lane swap and checks that repeat mode holds rather than zeroes.

// File: rtl/playfifo_pkg.sv
package playfifo_pkg;
  // bytes per stereo 16-bit sample
  localparam int unsigned SAMPLE_BYTES = 4;
  localparam int unsigned LANE_W       = $clog2(SAMPLE_BYTES);
  localparam logic [31:0] MIDSCALE     = 32'h0000_0000;

  // lane 0 = left low, 1 = left high, 2 = right low, 3 = right high
  function automatic logic [31:0] pack_sample(input logic [7:0] b0, input logic [7:0] b1,
                                              input logic [7:0] b2, input logic [7:0] b3);
    return {b1, b0, b3, b2};
  endfunction

  function automatic logic lane_is_left(input logic [LANE_W-1:0] lane);
    return ~lane[1];
  endfunction

  function automatic logic lane_is_upper(input logic [LANE_W-1:0] lane);
    return lane[0];
  endfunction
endpackage

// File: rtl/pb_byte_store.sv
module pb_byte_store
  import playfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  input  logic              pop_req,
  output logic              wr_ready,
  output logic              push,
  output logic              pop,
  output logic              avail,
  output logic [31:0]       head_sample,
  output logic [LANE_W-1:0] lane_q,
  output logic [LANE_W-1:0] lane_next,
  output logic [CW-1:0]     count_next
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
  logic [CW-1:0] count;
  logic [7:0]    head [SAMPLE_BYTES];

  assign wr_ready = (count < CW'(DEPTH));
  assign avail    = (count >= CW'(SAMPLE_BYTES));
  assign push     = wr_valid && wr_ready;
  assign pop      = pop_req && avail;

  assign wr_ptr_nx = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
  assign rd_ptr_nx = (rd_ptr == AW'(DEPTH - SAMPLE_BYTES)) ? '0 : rd_ptr + AW'(SAMPLE_BYTES);

  always_comb begin
    count_next = count;
    if (push) count_next = count_next + CW'(1);
    if (pop)  count_next = count_next - CW'(SAMPLE_BYTES);
  end

  assign lane_q    = wr_ptr[LANE_W-1:0];
  assign lane_next = push ? wr_ptr_nx[LANE_W-1:0] : wr_ptr[LANE_W-1:0];

  for (genvar l = 0; l < SAMPLE_BYTES; l++) begin : g_head
    assign head[l] = mem[rd_ptr + AW'(l)];
  end
  assign head_sample = pack_sample(head[0], head[1], head[2], head[3]);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr_nx;
      if (pop)  rd_ptr <= rd_ptr_nx;
      count <= count_next;
    end
  end
endmodule

// File: rtl/pb_status.sv
module pb_status
  import playfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned HALF = DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     count_next,
  input  logic [LANE_W-1:0] lane_next,
  output logic [7:0]        status
);
  logic [CW-1:0] free_next;
  logic [7:0]    status_d;

  assign free_next = CW'(DEPTH) - count_next;
  assign status_d  = {free_next >= CW'(HALF),
                      free_next >= CW'(SAMPLE_BYTES),
                      lane_is_left(lane_next),
                      lane_is_upper(lane_next),
                      4'b0000};

  always_ff @(posedge clk) begin
    if (!rst_n) status <= 8'h00;
    else        status <= status_d;
  end
endmodule

// File: rtl/pb_starve_ctl.sv
module pb_starve_ctl
  import playfifo_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        avail,
  input  logic        sample_done,
  input  logic        repeat_mode,
  input  logic [31:0] head_sample,
  output logic [31:0] dac_sample,
  output logic        underrun
);
  logic grace_q;
  logic starved;

  assign starved = tick && !avail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_sample <= '0;
    end else if (tick) begin
      if (avail)             dac_sample <= head_sample;
      else if (!repeat_mode) dac_sample <= MIDSCALE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grace_q  <= 1'b0;
      underrun <= 1'b0;
    end else if (sample_done) begin
      grace_q  <= 1'b0;
      underrun <= 1'b0;
    end else if (tick) begin
      grace_q <= starved;
      if (starved && grace_q) underrun <= 1'b1;
    end
  end
endmodule

// File: rtl/pio_playback_port.sv
module pio_playback_port
  import playfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [7:0]  wr_data,
  output logic        wr_ready,
  input  logic        tick,
  input  logic        repeat_mode,
  output logic [31:0] dac_sample,
  output logic [7:0]  pio_status,
  output logic        underrun
);
  logic              push, pop, avail;
  logic [31:0]       head_sample;
  logic [LANE_W-1:0] lane_q, lane_next;
  logic [CW-1:0]     count_next;
  logic              sample_done;

  assign sample_done = push && (lane_q == LANE_W'(SAMPLE_BYTES - 1));

  pb_byte_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .pop_req(tick), .wr_ready(wr_ready), .push(push), .pop(pop),
    .avail(avail), .head_sample(head_sample), .lane_q(lane_q),
    .lane_next(lane_next), .count_next(count_next)
  );

  pb_status #(.DEPTH(DEPTH)) u_status (
    .clk(clk), .rst_n(rst_n), .count_next(count_next),
    .lane_next(lane_next), .status(pio_status)
  );

  pb_starve_ctl u_starve (
    .clk(clk), .rst_n(rst_n), .tick(tick), .avail(avail),
    .sample_done(sample_done), .repeat_mode(repeat_mode),
    .head_sample(head_sample), .dac_sample(dac_sample), .underrun(underrun)
  );
endmodule

// File: rtl/pio_playback_port_chk.sv
module pio_playback_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic        tick,
  input logic [31:0] dac_sample,
  input logic [7:0]  pio_status,
  input logic        underrun
);
  AST_REQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    pio_status[6] |-> wr_ready); // R4
  AST_HALF_IMPLIES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    pio_status[7] |-> pio_status[6]); // R5
  AST_FULL_HOLDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !tick) |=> $stable(pio_status)); // R3
  AST_DAC_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(dac_sample)); // R7
  AST_UNDERRUN_SET_BY_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(tick)); // R8
  AST_UNDERRUN_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(underrun) |-> $past(wr_valid && wr_ready)); // R9
endmodule

bind pio_playback_port pio_playback_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .tick(tick), .dac_sample(dac_sample), .pio_status(pio_status),
  .underrun(underrun)
);

// File: tb/tb_pio_playback_port.sv
module tb_pio_playback_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        tick = 1'b0;
  logic        repeat_mode = 1'b0;
  logic        wr_ready;
  logic [31:0] dac_sample;
  logic [7:0]  pio_status;
  logic        underrun;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pio_playback_port dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .tick(tick), .repeat_mode(repeat_mode),
    .dac_sample(dac_sample), .pio_status(pio_status), .underrun(underrun)
  );

  // {is_tick, byte, expected status[7:4], expected underrun, expected dac}
  localparam int NV = 12;
  localparam logic [45:0] VEC [NV] = '{
    {1'b0, 8'h11, 4'hF, 1'b0, 32'h0000_0000},
    {1'b0, 8'h22, 4'hC, 1'b0, 32'h0000_0000},
    {1'b0, 8'h33, 4'hD, 1'b0, 32'h0000_0000},
    {1'b0, 8'h44, 4'hE, 1'b0, 32'h0000_0000},
    {1'b1, 8'h00, 4'hE, 1'b0, 32'h2211_4433},
    {1'b1, 8'h00, 4'hE, 1'b0, 32'h0000_0000},
    {1'b1, 8'h00, 4'hE, 1'b1, 32'h0000_0000},
    {1'b0, 8'hAA, 4'hF, 1'b1, 32'h0000_0000},
    {1'b0, 8'hBB, 4'hC, 1'b1, 32'h0000_0000},
    {1'b0, 8'hCC, 4'hD, 1'b1, 32'h0000_0000},
    {1'b0, 8'hDD, 4'hE, 1'b0, 32'h0000_0000},
    {1'b1, 8'h00, 4'hE, 1'b0, 32'hBBAA_DDCC}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); wr_valid = 1'b1; wr_data = b;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #4ms;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 status", {24'h0, pio_status}, 32'h0);
    check("R1 underrun", {31'h0, underrun}, 32'h0);
    check("R1 dac", dac_sample, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 R4 R5 R10 idle status", {24'h0, pio_status}, 32'hE0);

    // table walk: R2 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][45]) pulse_tick();
      else            put(VEC[i][44:37]);
      check("R2 R4 R5 status", {24'h0, pio_status}, {24'h0, VEC[i][36:33], 4'h0});
      check("R8 R9 underrun", {31'h0, underrun}, {31'h0, VEC[i][32]});
      check("R6 R7 dac", dac_sample, VEC[i][31:0]);
    end

    // R7 repeat mode holds, R8 sets after grace
    repeat_mode = 1'b1;
    pulse_tick();
    check("R7 repeat hold", dac_sample, 32'hBBAA_DDCC);
    check("R8 grace tick", {31'h0, underrun}, 32'h0);
    pulse_tick();
    check("R7 repeat hold 2", dac_sample, 32'hBBAA_DDCC);
    check("R8 second starve", {31'h0, underrun}, 32'h1);
    pulse_tick();
    check("R8 sticky", {31'h0, underrun}, 32'h1);

    // R3: fill to full
    for (int i = 0; i < 64; i++) put(8'(i));
    check("R9 cleared by fill", {31'h0, underrun}, 32'h0);
    check("R3 full ready", {31'h0, wr_ready}, 32'h0);
    check("R3 R4 R5 full status", {24'h0, pio_status}, 32'h20);
    put(8'hEE);
    check("R3 refused byte keeps position", {24'h0, pio_status}, 32'h20);
    pulse_tick();
    check("R6 first sample", dac_sample, 32'h0100_0302);
    check("R4 req after pop", {24'h0, pio_status}, 32'h60);
    check("R3 ready after pop", {31'h0, wr_ready}, 32'h1);
    for (int i = 0; i < 6; i++) pulse_tick();
    check("R5 28 free", {24'h0, pio_status}, 32'h60);
    pulse_tick();
    check("R5 32 free", {24'h0, pio_status}, 32'hE0);
    check("R6 eighth sample", dac_sample, 32'h1D1C_1F1E);

    finish_run();
  end
endmodule